// File: doc/BRIEF.md
# SPI Port Controller with Master-Loss Detection

This block is an 8-bit serial peripheral interface that works either as the clock-generating master or as a clocked slave. The choice is made by a bit in its control register. Software reaches three byte-wide registers over a small synchronous bus: control, status and data. The block drives SCK, MOSI and MISO, samples SS, and reports for each pin whether it should be driven. An interrupt request output follows the transfer-complete flag.

One 8-bit shift register carries both directions at once. Outgoing data is single-buffered, so the next byte may be written only after the running exchange has finished. Incoming data is double-buffered: each completed byte is copied into a receive holding register, which software reads while the next byte shifts in.

A master whose SS pin is set as an input treats a low level on that pin as another master claiming the bus. It turns itself into a slave, releases SCK and MOSI and raises the complete flag. It stays a slave until software sets the master bit again.

Top module: `spi_port_ctrl`

## Requirements
- R1: Register map. Address 0 is control: bit0 enable, bit1 master, bit2 clock idle level, bit3 sample phase, bit4 LSB-first, bit5 interrupt enable, bits 7:6 rate. Address 1 is status: bit0 complete, bit1 write collision. Address 2 is data. In master mode, a data write when idle starts an exchange of 8 bits, sent MSB first when bit4 is 0 and LSB first when bit4 is 1. The byte received from MISO is then read back from address 2.
- R2: In master mode, each SCK half-period lasts 2, 8, 32 or 64 system clocks for rate values 0, 1, 2 and 3 (SCK at clock/4, /16, /64 and /128).
- R3: SCK rests at the level of control bit2. With bit3 = 0, data is sampled on the first edge of each bit and changed on the second edge. With bit3 = 1, data is changed on the first edge and sampled on the second. This holds in both master and slave mode.
- R4: A completed byte stays readable at address 2 while the next exchange runs. A byte that is not read before the following exchange completes is replaced by the newer byte.
- R5: A data write during a running exchange is discarded and sets status bit1. The exchange in progress keeps sending the original byte.
- R6: Status bits 0 and 1 clear after a status read that saw bit0 set, followed by any read or write of address 2. irq is high exactly while status bit0 and control bit5 are both set.
- R7: In master mode with SS set as an input (usr_dir bit3 = 0), a low SS clears the master bit, sets status bit0 and releases SCK and MOSI. The master bit stays clear after SS returns high.
- R8: In master mode with SS set as an output (usr_dir bit3 = 1), the level on ss_i has no effect on the master bit or the status.
- R9: In slave mode with SS high, SCK edges are ignored and the bit count returns to zero. A byte aborted by SS rising therefore does not disturb the next full exchange.
- R10: For pin_oe and usr_dir, bit0 is SCK, bit1 MOSI, bit2 MISO and bit3 SS. When disabled, pin_oe equals usr_dir. In master mode, MISO is forced to 0 and the other bits follow usr_dir. In slave mode, SCK, MOSI and SS are forced to 0, and MISO follows usr_dir bit2 only while SS is low.
- R11: In slave mode with SS low, the block shifts out the last written byte on MISO and captures MOSI on the external SCK. After 8 bits it sets status bit0 and places the captured byte at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | SCK level on the pin (slave clock) |
| sck_o | output | 1 | Generated SCK |
| mosi_i | input | 1 | MOSI level on the pin |
| mosi_o | output | 1 | Outgoing serial bit in master mode |
| miso_i | input | 1 | MISO level on the pin |
| miso_o | output | 1 | Outgoing serial bit in slave mode |
| ss_i | input | 1 | SS level on the pin |
| usr_dir | input | 4 | Software pin directions (1 = output) |
| pin_oe | output | 4 | Effective output enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench acts as the far end of the link in all four clock modes and in both bit orders, so a design that mixed up sample and change edges, or reversed the bit order, would return garbled bytes. It writes during a running exchange: an engine that accepted that write would corrupt the byte on the wire or leave the collision flag clear. It reads the holding register in the middle of the next exchange and again after a second unread byte; a single-buffered receiver would return partial or stale data. It also pulls SS low with SS set as input and again with SS set as output, and it aborts a slave byte halfway through. A design that ignored the loss of mastership, reacted to a general-purpose SS, or kept a stale bit count would fail these cases.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int DW       = 8;
    localparam int CNT_W    = 4;
    localparam int CB_EN    = 0;
    localparam int CB_MST   = 1;
    localparam int CB_CPOL  = 2;
    localparam int CB_CPHA  = 3;
    localparam int CB_LSB   = 4;
    localparam int CB_IRQ   = 5;
    localparam int CB_RATE  = 6;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int PIN_SCK  = 0;
    localparam int PIN_MOSI = 1;
    localparam int PIN_MISO = 2;
    localparam int PIN_SS   = 3;

    typedef struct packed {
        logic [DW-1:0]    ctrl;
        logic             done;
        logic             wcol;
        logic             armed;
        logic             busy;
        logic [CNT_W-1:0] ecnt;
        logic [DW-1:0]    shreg;
        logic [DW-1:0]    rxbuf;
        logic             drv;
        logic             sck;
        logic             sck_prev;
    } spi_state_t;

    function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] sh, input logic b,
                                                input logic lsb);
        return lsb ? {b, sh[DW-1:1]} : {sh[DW-2:0], b};
    endfunction

    function automatic logic out_bit(input logic [DW-1:0] sh, input logic lsb);
        return lsb ? sh[0] : sh[DW-1];
    endfunction
endpackage

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe_q[k] <= RST;
        end else begin
            pipe_q[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_port_rate.sv
`timescale 1ns/1ps
module spi_port_rate #(
    parameter int DIV0 = 4,
    parameter int DIV1 = 16,
    parameter int DIV2 = 64,
    parameter int DIV3 = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int CW = $clog2(DIV3 / 2 + 1);
    localparam logic [CW-1:0] H0 = CW'(DIV0 / 2 - 1);
    localparam logic [CW-1:0] H1 = CW'(DIV1 / 2 - 1);
    localparam logic [CW-1:0] H2 = CW'(DIV2 / 2 - 1);
    localparam logic [CW-1:0] H3 = CW'(DIV3 / 2 - 1);

    logic [CW-1:0] cnt_d, cnt_q, last;

    always_comb begin
        unique case (sel)
            2'd0:    last = H0;
            2'd1:    last = H1;
            2'd2:    last = H2;
            default: last = H3;
        endcase
        tick  = run && (cnt_q == last);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port_ctrl.sv
`timescale 1ns/1ps
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int DIV0 = 4,
    parameter int DIV1 = 16,
    parameter int DIV2 = 64,
    parameter int DIV3 = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          sck_i,
    output logic          sck_o,
    input  logic          mosi_i,
    output logic          mosi_o,
    input  logic          miso_i,
    output logic          miso_o,
    input  logic          ss_i,
    input  logic [3:0]    usr_dir,
    output logic [3:0]    pin_oe,
    output logic          irq
);
    localparam logic [CNT_W-1:0] M_LAST = CNT_W'(2 * DW - 1);
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(DW - 1);

    spi_state_t st_d, st_q;
    logic [DW-1:0] ctrl_r;
    logic sck_s, mosi_s, ss_s;
    logic en, mst, cpol, cpha, lsb;
    logic rate_tick, slv_active, xfer_busy, fault, data_acc;
    logic done_r, wcol_r;

    spi_port_sync #(.W(3), .STAGES(2), .RST(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_i, mosi_i, sck_i}), .q({ss_s, mosi_s, sck_s})
    );

    spi_port_rate #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(st_q.busy),
        .sel(ctrl_r[CB_RATE+1:CB_RATE]), .tick(rate_tick)
    );

    assign ctrl_r     = st_q.ctrl;
    assign done_r     = st_q.done;
    assign wcol_r     = st_q.wcol;
    assign en         = ctrl_r[CB_EN];
    assign mst        = ctrl_r[CB_MST];
    assign cpol       = ctrl_r[CB_CPOL];
    assign cpha       = ctrl_r[CB_CPHA];
    assign lsb        = ctrl_r[CB_LSB];
    assign slv_active = en && !mst && !ss_s;
    assign xfer_busy  = st_q.busy || (slv_active && st_q.ecnt != '0);
    assign fault      = en && mst && !usr_dir[PIN_SS] && !ss_s;
    assign data_acc   = (bus_wr || bus_rd) && bus_addr == A_DATA;

    always_comb begin
        logic lead;
        logic samp;
        st_d = st_q;
        st_d.sck_prev = sck_s;
        lead = 1'b0;
        samp = 1'b0;

        // flag clear sequence: status read seen with done set, then data access
        if (st_q.armed && data_acc) begin
            st_d.done  = 1'b0;
            st_d.wcol  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (bus_rd && bus_addr == A_STAT && st_q.done) st_d.armed = 1'b1;

        // master engine: one rate tick per SCK edge, 16 edges per byte
        if (!st_q.busy) begin
            st_d.sck = cpol;
        end else if (rate_tick) begin
            lead     = ~st_q.ecnt[0];
            samp     = lead ^ cpha;
            st_d.sck = ~st_q.sck;
            if (samp) st_d.shreg = shift_in(st_q.shreg, miso_i, lsb);
            else      st_d.drv   = out_bit(st_q.shreg, lsb);
            st_d.ecnt = st_q.ecnt + 1'b1;
            if (st_q.ecnt == M_LAST) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.rxbuf = st_d.shreg;
            end
        end

        // slave engine: edges of the synchronised external clock
        if (en && !mst) begin
            if (ss_s) begin
                st_d.ecnt = '0;
                st_d.drv  = out_bit(st_q.shreg, lsb);
            end else if (sck_s != st_q.sck_prev) begin
                lead = (sck_s != cpol);
                samp = lead ^ cpha;
                if (samp) begin
                    st_d.shreg = shift_in(st_q.shreg, mosi_s, lsb);
                    if (st_q.ecnt == S_LAST) begin
                        st_d.ecnt  = '0;
                        st_d.done  = 1'b1;
                        st_d.rxbuf = st_d.shreg;
                    end else begin
                        st_d.ecnt = st_q.ecnt + 1'b1;
                    end
                end else begin
                    st_d.drv = out_bit(st_q.shreg, lsb);
                end
            end
        end

        if (!en) begin
            st_d.busy = 1'b0;
            st_d.ecnt = '0;
        end

        if (bus_wr && bus_addr == A_CTRL) st_d.ctrl = bus_wdata;

        if (bus_wr && bus_addr == A_DATA) begin
            if (xfer_busy) begin
                st_d.wcol = 1'b1;
            end else begin
                st_d.shreg = bus_wdata;
                st_d.drv   = out_bit(bus_wdata, lsb);
                if (en && mst) begin
                    st_d.busy = 1'b1;
                    st_d.ecnt = '0;
                end
            end
        end

        // loss of mastership overrides everything else this cycle
        if (fault) begin
            st_d.ctrl[CB_MST] = 1'b0;
            st_d.done         = 1'b1;
            st_d.busy         = 1'b0;
            st_d.ecnt         = '0;
            st_d.sck          = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_r;
            A_STAT:  bus_rdata = {6'b0, st_q.wcol, st_q.done};
            A_DATA:  bus_rdata = st_q.rxbuf;
            default: bus_rdata = '0;
        endcase
        if (!en)      pin_oe = usr_dir;
        else if (mst) pin_oe = {usr_dir[PIN_SS], 1'b0, usr_dir[PIN_MOSI], usr_dir[PIN_SCK]};
        else          pin_oe = {1'b0, usr_dir[PIN_MISO] & ~ss_s, 2'b00};
    end

    assign sck_o  = st_q.sck;
    assign mosi_o = st_q.drv;
    assign miso_o = st_q.drv;
    assign irq    = st_q.done && ctrl_r[CB_IRQ];
endmodule

// File: rtl/spi_port_ctrl_chk.sv
`timescale 1ns/1ps
module spi_port_ctrl_chk
    import spi_port_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ctrl_r,
    input logic          ss_s,
    input logic [3:0]    usr_dir,
    input logic [3:0]    pin_oe,
    input logic          done_r,
    input logic          wcol_r,
    input logic          xfer_busy,
    input logic          bus_wr,
    input logic [1:0]    bus_addr
);
    logic en_m, en_s, ss_in_low;
    assign en_m      = ctrl_r[CB_EN] && ctrl_r[CB_MST];
    assign en_s      = ctrl_r[CB_EN] && !ctrl_r[CB_MST];
    assign ss_in_low = !usr_dir[PIN_SS] && !ss_s;

    AST_MASTER_MISO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        en_m |-> !pin_oe[PIN_MISO]); // R10
    AST_SLAVE_PINS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |-> (!pin_oe[PIN_SCK] && !pin_oe[PIN_MOSI] && !pin_oe[PIN_SS])); // R10
    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (en_m && ss_in_low) |=> !ctrl_r[CB_MST]); // R7
    AST_FAULT_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_m && ss_in_low) |=> done_r); // R7
    AST_WRITE_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && xfer_busy) |=> wcol_r); // R5
    AST_SS_OUTPUT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_m && usr_dir[PIN_SS] && !(bus_wr && bus_addr == A_CTRL)) |=> ctrl_r[CB_MST]); // R8
endmodule

bind spi_port_ctrl spi_port_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_r(ctrl_r), .ss_s(ss_s), .usr_dir(usr_dir),
    .pin_oe(pin_oe), .done_r(done_r), .wcol_r(wcol_r), .xfer_busy(xfer_busy),
    .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/spi_port_ctrl_bench.sv
`timescale 1ns/1ps
module spi_port_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_r = 1'b0, ss_i = 1'b1;
    logic       sck_o, mosi_o, miso_o, irq;
    logic [3:0] usr_dir = 4'b0000, pin_oe;

    int n_chk = 0, n_fail = 0;
    logic b_cpol = 0, b_cpha = 0, b_lsb = 0;
    logic model_on = 0;
    logic [7:0] m_tx = 0, got_r = 0;
    int idx_in = 0, idx_out = 0, nedge = 0, half_meas = 0;
    time t_e1 = 0;

    spi_port_ctrl u_spi_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(miso_r), .miso_o(miso_o), .ss_i(ss_i),
        .usr_dir(usr_dir), .pin_oe(pin_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic int bp(input int i, input logic l);
        return l ? i : 7 - i;
    endfunction

    function automatic logic [7:0] mk_ctrl(input logic [1:0] rate, input logic ie, input logic l,
                                           input logic ph, input logic po, input logic m);
        return {rate, ie, l, ph, po, m, 1'b1};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // far-end slave model for master-mode tests
    always @(sck_o) begin
        if (model_on) begin
            nedge++;
            if (nedge == 1) t_e1 = $time;
            if (nedge == 2) half_meas = int'(($time - t_e1) / 20);
            if (((sck_o != b_cpol) ? 1'b1 : 1'b0) ^ b_cpha) begin
                if (idx_in < 8) got_r[bp(idx_in, b_lsb)] = mosi_o;
                idx_in++;
            end else if (idx_out < 8) begin
                miso_r = m_tx[bp(idx_out, b_lsb)];
                idx_out++;
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic model_arm(input logic [7:0] sv);
        m_tx = sv; idx_in = 0; idx_out = 0; nedge = 0; got_r = 0;
        if (!b_cpha) begin miso_r = sv[bp(0, b_lsb)]; idx_out = 1; end
        model_on = 1;
    endtask

    task automatic wait_done(input string req);
        logic [7:0] s;
        s = 0;
        for (int k = 0; k < 5000; k++) begin
            bus_read(2'd1, s);
            if (s[0]) break;
        end
        chk(s[0], req, s, 1);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench acting as master toward the block in slave mode
    task automatic slv_xfer(input logic [7:0] m, output logic [7:0] g);
        const int H = 6;
        g = 0;
        ss_i = 1'b0;
        if (!b_cpha) mosi_i = m[bp(0, b_lsb)];
        cycles(H);
        for (int i = 0; i < 8; i++) begin
            if (!b_cpha) begin
                g[bp(i, b_lsb)] = miso_o;
                sck_i = ~b_cpol;
                cycles(H);
                sck_i = b_cpol;
                if (i < 7) mosi_i = m[bp(i + 1, b_lsb)];
                cycles(H);
            end else begin
                sck_i = ~b_cpol;
                mosi_i = m[bp(i, b_lsb)];
                cycles(H);
                g[bp(i, b_lsb)] = miso_o;
                sck_i = b_cpol;
                cycles(H);
            end
        end
        cycles(6);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [7:0] s, rx, g, tx, sv, t2, s2, s3;
        logic [1:0] rate;
        void'($urandom(32'd20240611));
        usr_dir = 4'b1011;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);

        // reset state
        bus_read(2'd0, s); chk(s == 8'h00, "R1 ctrl reset", s, 0);
        bus_read(2'd1, s); chk(s == 8'h00, "R6 status reset", s, 0);
        chk(pin_oe == 4'b1011, "R10 disabled pass-through", pin_oe, 4'b1011);
        chk(irq == 1'b0, "R6 irq reset", irq, 0);

        // random master exchanges
        usr_dir = 4'b1011;
        for (int it = 0; it < 14; it++) begin
            rate = 2'($urandom % 4);
            b_cpol = 1'($urandom); b_cpha = 1'($urandom); b_lsb = 1'($urandom);
            tx = 8'($urandom); sv = 8'($urandom);
            bus_write(2'd0, mk_ctrl(rate, 1'b0, b_lsb, b_cpha, b_cpol, 1'b1));
            cycles(2);
            chk(sck_o == b_cpol, "R3 master idle level", sck_o, b_cpol);
            model_arm(sv);
            bus_write(2'd2, tx);
            wait_done("R1 master completes");
            model_on = 0;
            bus_read(2'd2, rx);
            chk(rx == sv, "R1 R3 master receive", rx, sv);
            chk(got_r == tx, "R1 R3 master send order", got_r, tx);
            chk(half_meas == (2 << (2 * rate)) / ((rate == 2'd3) ? 2 : 1) || (rate == 2'd3 && half_meas == 64),
                "R2 half period", half_meas, (rate == 2'd3) ? 64 : (2 << (2 * rate)));
            bus_read(2'd1, s);
            chk(s[0] == 1'b0, "R6 done cleared", s, 0);
            cycles(2);
            chk(sck_o == b_cpol, "R3 master returns idle", sck_o, b_cpol);
        end

        // interrupt follows done and enable
        b_cpol = 0; b_cpha = 0; b_lsb = 0;
        bus_write(2'd0, mk_ctrl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        model_arm(8'h5A);
        bus_write(2'd2, 8'hC3);
        cycles(60);
        chk(irq == 1'b1, "R6 irq raised", irq, 1);
        bus_read(2'd1, s);
        bus_read(2'd2, rx);
        model_on = 0;
        cycles(1);
        chk(irq == 1'b0, "R6 irq cleared", irq, 0);

        // write collision
        bus_write(2'd0, mk_ctrl(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1));
        b_lsb = 1; b_cpha = 1;
        cycles(2);
        model_arm(8'h96);
        bus_write(2'd2, 8'h3C);
        cycles(10);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd1, s);
        chk(s[1] == 1'b1, "R5 wcol set", s, 2);
        wait_done("R5 exchange completes");
        model_on = 0;
        chk(got_r == 8'h3C, "R5 original byte sent", got_r, 8'h3C);
        bus_read(2'd2, rx);
        chk(rx == 8'h96, "R5 receive unaffected", rx, 8'h96);
        bus_read(2'd1, s);
        chk(s[1:0] == 2'b00, "R6 wcol and done cleared", s, 0);

        // receive double buffering
        b_lsb = 0; b_cpha = 0;
        bus_write(2'd0, mk_ctrl(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cycles(2);
        sv = 8'hA1; s2 = 8'h4E; s3 = 8'h17; t2 = 8'h88;
        model_arm(sv); bus_write(2'd2, 8'h01); wait_done("R4 first byte");
        model_arm(s2); bus_write(2'd2, t2);
        cycles(40);
        bus_read(2'd2, rx);
        chk(rx == sv, "R4 previous byte held during shift", rx, sv);
        wait_done("R4 second byte");
        model_arm(s3); bus_write(2'd2, 8'h02); wait_done("R4 third byte");
        model_on = 0;
        bus_read(2'd2, rx);
        chk(rx == s3, "R4 unread byte overwritten", rx, s3);

        // pin overrides in master, SS as output, loss of mastership
        usr_dir = 4'b0011;
        bus_write(2'd0, mk_ctrl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        cycles(2);
        chk(pin_oe == 4'b0011, "R10 master oe", pin_oe, 4'b0011);
        usr_dir = 4'b1111;
        cycles(1);
        chk(pin_oe == 4'b1011, "R10 master forces MISO in", pin_oe, 4'b1011);
        usr_dir = 4'b1011; ss_i = 1'b0;
        cycles(6);
        bus_read(2'd0, s); chk(s[1] == 1'b1, "R8 master kept", s, 1);
        bus_read(2'd1, s); chk(s[0] == 1'b0, "R8 no flag", s, 0);
        usr_dir = 4'b0011;
        cycles(6);
        bus_read(2'd0, s); chk(s[1] == 1'b0, "R7 master cleared", s, 0);
        bus_read(2'd1, s); chk(s[0] == 1'b1, "R7 flag set", s, 1);
        chk(irq == 1'b1, "R7 irq raised", irq, 1);
        chk(pin_oe[1:0] == 2'b00, "R7 SCK MOSI released", pin_oe, 0);
        ss_i = 1'b1;
        cycles(6);
        bus_read(2'd0, s); chk(s[1] == 1'b0, "R7 stays slave", s, 0);
        bus_read(2'd2, rx);

        // random slave exchanges
        usr_dir = 4'b1111;
        for (int it = 0; it < 8; it++) begin
            b_cpol = 1'($urandom); b_cpha = 1'($urandom); b_lsb = 1'($urandom);
            tx = 8'($urandom); sv = 8'($urandom);
            ss_i = 1'b1; sck_i = b_cpol;
            bus_write(2'd0, mk_ctrl(2'd0, 1'b0, b_lsb, b_cpha, b_cpol, 1'b0));
            cycles(5);
            chk(pin_oe == 4'b0000, "R10 slave idle all inputs", pin_oe, 0);
            bus_write(2'd2, tx);
            cycles(3);
            slv_xfer(sv, g);
            chk(pin_oe == 4'b0100, "R10 slave drives MISO", pin_oe, 4'b0100);
            chk(g == tx, "R11 slave send", g, tx);
            bus_read(2'd1, s); chk(s[0] == 1'b1, "R11 slave done", s, 1);
            bus_read(2'd2, rx); chk(rx == sv, "R11 slave receive", rx, sv);
            ss_i = 1'b1;
            cycles(4);
        end

        // SS high ignores clocks, abort resets bit count
        b_cpol = 0; b_cpha = 0; b_lsb = 0;
        bus_write(2'd0, mk_ctrl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        sck_i = 1'b0; ss_i = 1'b1;
        cycles(5);
        for (int k = 0; k < 9; k++) begin
            mosi_i = 1'($urandom); sck_i = 1'b1; cycles(6); sck_i = 1'b0; cycles(6);
        end
        bus_read(2'd1, s); chk(s[0] == 1'b0, "R9 clocks ignored with SS high", s, 0);
        ss_i = 1'b0; cycles(6);
        for (int k = 0; k < 3; k++) begin
            mosi_i = 1'b1; sck_i = 1'b1; cycles(6); sck_i = 1'b0; cycles(6);
        end
        ss_i = 1'b1; cycles(5);
        bus_write(2'd2, 8'h6D);
        cycles(3);
        slv_xfer(8'hB2, g);
        chk(g == 8'h6D, "R9 send after abort", g, 8'h6D);
        bus_read(2'd1, s); chk(s[0] == 1'b1, "R9 done after full byte", s, 1);
        bus_read(2'd2, rx); chk(rx == 8'hB2, "R9 receive after abort", rx, 8'hB2);
        ss_i = 1'b1;
        cycles(4);

        report();
        $finish;
    end
endmodule